// File: doc/BRIEF.md
# Dual-Mode Parallel Host Write Port

This block is the write side of a display controller's host port. A microprocessor drives bytes onto an 8-bit parallel bus, and the block carries them into the controller's system clock domain. Two bus styles are supported, and static mode pins select between them. In the strobe-per-direction style, a byte is taken when the active-low write strobe returns high. In the enable-plus-direction style, a byte is taken when the enable falls while the direction line reads "write". The register-select line tags each byte as display data or as a control command.

All bus inputs are asynchronous to the system clock. They pass through a synchronizer chain together, so the data and tag used for a byte are the values that travelled alongside the strobe. Each accepted byte appears as a single-cycle valid pulse with its data and tag. The bus can never be read back, so the data-bus output enable is held off. Any mode-pin value other than the two parallel encodings stops capture and raises a status flag.

Top module: `hostbus_wr_port`

## Requirements
- R1: The mode pins select the bus style: 3'b001 selects strobe-per-direction timing and 3'b011 selects enable-plus-direction timing. Every other value drives mode_unsupported high, and no byte_valid pulse is produced while it is high. For the two parallel encodings, mode_unsupported is low.
- R2: In strobe-per-direction mode, a byte is accepted on each low-to-high transition of bus_wr_rw. Toggling bus_rd_en in this mode produces no pulse.
- R3: In enable-plus-direction mode, a byte is accepted on each high-to-low transition of bus_rd_en, provided bus_wr_rw is low. A falling edge seen while bus_wr_rw is high produces no pulse, and neither does a rising edge of bus_rd_en.
- R4: A strobe edge that occurs while bus_sel_n is high produces no pulse.
- R5: Each accepted edge yields exactly one byte_valid pulse, one clock wide. With the default two synchronizer stages, the pulse is high in the third clock after the edge is set up on the bus.
- R6: While byte_valid is high, byte_data equals the bus byte held across the accepted edge. is_data is 1 if bus_dc was high and 0 if bus_dc was low.
- R7: db_oe is 0 at all times.
- R8: While rst_n is low, byte_valid, byte_data and is_data are 0, and strobe edges produce no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_sel | input | 3 | Static bus-style select |
| bus_sel_n | input | 1 | Active-low chip select |
| bus_dc | input | 1 | Register select: 1 = display data, 0 = command |
| bus_wr_rw | input | 1 | Write strobe (active low) or direction line (0 = write), depending on mode |
| bus_rd_en | input | 1 | Read strobe (ignored) or enable, depending on mode |
| db_in | input | 8 | Parallel data bus |
| db_oe | output | 1 | Data bus output enable, always 0 |
| byte_valid | output | 1 | One-cycle pulse per accepted byte |
| byte_data | output | 8 | Accepted byte |
| is_data | output | 1 | Tag of accepted byte |
| mode_unsupported | output | 1 | Mode pins hold a non-parallel encoding |

## Verification
Both bus styles are driven with command and data bytes, including all-zero, all-one and alternating patterns. This shows that the data and the tag travel with the strobe and are not mixed up. Negative patterns are applied for each way a byte can be rejected: a read-strobe toggle in the first style, an enable edge with the direction line high, edges with chip select high, edges under unsupported mode encodings, and edges during reset. A scoreboard flags any pulse that is missing or unexpected. One directed write pins down the exact pulse cycle.

// File: rtl/hbw_pkg.sv
package hbw_pkg;

   localparam int unsigned MODE_W = 3;

   typedef enum logic [MODE_W-1:0] {
      MODE_I80  = 3'b001,
      MODE_M68  = 3'b011
   } bus_mode_e;

   // Control lines carried through the synchronizer next to the data bus
   localparam int unsigned CTRL_W = 4;
   localparam int unsigned IDX_SEL = 3;
   localparam int unsigned IDX_DC  = 2;
   localparam int unsigned IDX_WR  = 1;
   localparam int unsigned IDX_EN  = 0;

   // Idle values: chip select off, write strobe high, enable low
   localparam logic [CTRL_W-1:0] CTRL_IDLE = 4'b1010;

   function automatic logic is_i80(input logic [MODE_W-1:0] m);
      return m == MODE_I80;
   endfunction

   function automatic logic is_m68(input logic [MODE_W-1:0] m);
      return m == MODE_M68;
   endfunction

endpackage

// File: rtl/hbw_sync.sv
module hbw_sync #(
   parameter int unsigned WIDTH  = 12,
   parameter int unsigned STAGES = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_async,
   output logic [WIDTH-1:0] q_sync
);

   if (STAGES < 2) begin : g_bad_stages
      $error("hbw_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("hbw_sync: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= RST_VAL;
            else        chain[s] <= d_async;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= RST_VAL;
            else        chain[s] <= chain[s-1];
         end
      end
   end

   assign q_sync = chain[STAGES-1];

endmodule

// File: rtl/hbw_mode_dec.sv
module hbw_mode_dec
   import hbw_pkg::*;
(
   input  logic [MODE_W-1:0] mode_sel,
   output logic              sel_i80,
   output logic              sel_m68,
   output logic              unsupported
);

   always_comb begin
      sel_i80     = is_i80(mode_sel);
      sel_m68     = is_m68(mode_sel);
      unsupported = !(sel_i80 || sel_m68);
   end

endmodule

// File: rtl/hbw_strobe_det.sv
module hbw_strobe_det (
   input  logic clk,
   input  logic rst_n,
   input  logic sel_i80,
   input  logic sel_m68,
   input  logic s_sel_n,
   input  logic s_wr,
   input  logic s_en,
   output logic fire
);

   logic prev_wr;
   logic prev_en;
   logic wr_rise;
   logic en_fall;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_wr <= 1'b1;
         prev_en <= 1'b0;
      end else begin
         prev_wr <= s_wr;
         prev_en <= s_en;
      end
   end

   always_comb begin
      wr_rise = s_wr && !prev_wr;
      en_fall = prev_en && !s_en;
      fire    = !s_sel_n &&
                ((sel_i80 && wr_rise) || (sel_m68 && en_fall && !s_wr));
   end

   // R2: a qualifying edge in the strobe-per-direction style is a rise
   a_r2_i80_rise: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && sel_i80) |=> prev_wr);

   // R3: an accepted enable edge leaves the enable low
   a_r3_m68_fall: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && sel_m68) |=> !prev_en);

endmodule

// File: rtl/hbw_capture.sv
module hbw_capture #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fire,
   input  logic [DATA_W-1:0] s_db,
   input  logic              s_dc,
   output logic              byte_valid,
   output logic [DATA_W-1:0] byte_data,
   output logic              is_data
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         byte_valid <= 1'b0;
         byte_data  <= '0;
         is_data    <= 1'b0;
      end else begin
         byte_valid <= fire;
         if (fire) begin
            byte_data <= s_db;
            is_data   <= s_dc;
         end
      end
   end

   // R5: a pulse never lasts longer than one clock
   a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      byte_valid |=> !byte_valid);

   // R6: output holds between pulses
   a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !fire |=> $stable(byte_data) && $stable(is_data));

endmodule

// File: rtl/hostbus_wr_port.sv
module hostbus_wr_port
   import hbw_pkg::*;
#(
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        mode_sel,
   input  logic              bus_sel_n,
   input  logic              bus_dc,
   input  logic              bus_wr_rw,
   input  logic              bus_rd_en,
   input  logic [DATA_W-1:0] db_in,
   output logic              db_oe,
   output logic              byte_valid,
   output logic [DATA_W-1:0] byte_data,
   output logic              is_data,
   output logic              mode_unsupported
);

   localparam int unsigned BUS_W = DATA_W + CTRL_W;
   localparam logic [BUS_W-1:0] BUS_IDLE = {CTRL_IDLE, {DATA_W{1'b0}}};

   if (DATA_W < 1) begin : g_bad_data_w
      $error("hostbus_wr_port: DATA_W must be at least 1");
   end

   logic [BUS_W-1:0] bus_raw;
   logic [BUS_W-1:0] bus_s;
   logic             s_sel_n;
   logic             s_dc;
   logic             s_wr;
   logic             s_en;
   logic [DATA_W-1:0] s_db;
   logic             sel_i80;
   logic             sel_m68;
   logic             fire;

   assign bus_raw = {bus_sel_n, bus_dc, bus_wr_rw, bus_rd_en, db_in};

   hbw_sync #(
      .WIDTH   (BUS_W),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (BUS_IDLE)
   ) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (bus_raw),
      .q_sync  (bus_s)
   );

   assign s_sel_n = bus_s[DATA_W + IDX_SEL];
   assign s_dc    = bus_s[DATA_W + IDX_DC];
   assign s_wr    = bus_s[DATA_W + IDX_WR];
   assign s_en    = bus_s[DATA_W + IDX_EN];
   assign s_db    = bus_s[DATA_W-1:0];

   hbw_mode_dec u_mode (
      .mode_sel    (mode_sel),
      .sel_i80     (sel_i80),
      .sel_m68     (sel_m68),
      .unsupported (mode_unsupported)
   );

   hbw_strobe_det u_det (
      .clk     (clk),
      .rst_n   (rst_n),
      .sel_i80 (sel_i80),
      .sel_m68 (sel_m68),
      .s_sel_n (s_sel_n),
      .s_wr    (s_wr),
      .s_en    (s_en),
      .fire    (fire)
   );

   hbw_capture #(
      .DATA_W (DATA_W)
   ) u_cap (
      .clk        (clk),
      .rst_n      (rst_n),
      .fire       (fire),
      .s_db       (s_db),
      .s_dc       (s_dc),
      .byte_valid (byte_valid),
      .byte_data  (byte_data),
      .is_data    (is_data)
   );

   // The bus is never read back
   assign db_oe = 1'b0;

   // R1: no pulse follows a cycle with an unsupported encoding
   a_r1_unsupported_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      $past(mode_unsupported) |-> !byte_valid);

   // R4: a pulse only follows a cycle with chip select active
   a_r4_sel_gate: assert property (@(posedge clk) disable iff (!rst_n)
      byte_valid |-> !$past(s_sel_n));

   // R3: enable-style bytes are writes only
   a_r3_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_valid && $past(sel_m68)) |-> !$past(s_wr));

   // R6: the tag comes from the synchronized register-select line
   a_r6_tag: assert property (@(posedge clk) disable iff (!rst_n)
      byte_valid |-> (is_data == $past(s_dc)) && (byte_data == $past(s_db)));

endmodule

// File: tb/tb_hostbus_wr_port.sv
module tb_hostbus_wr_port;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] mode_sel = 3'b001;
   logic       bus_sel_n = 1'b1;
   logic       bus_dc = 1'b0;
   logic       bus_wr_rw = 1'b1;
   logic       bus_rd_en = 1'b1;
   logic [7:0] db_in = 8'h00;
   logic       db_oe;
   logic       byte_valid;
   logic [7:0] byte_data;
   logic       is_data;
   logic       mode_unsupported;

   int tests = 0;
   int fails = 0;
   int pulses = 0;
   int oe_seen = 0;
   logic [8:0] exp_q [$];

   always #2 clk = ~clk;

   hostbus_wr_port dut (
      .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .bus_sel_n(bus_sel_n),
      .bus_dc(bus_dc), .bus_wr_rw(bus_wr_rw), .bus_rd_en(bus_rd_en),
      .db_in(db_in), .db_oe(db_oe), .byte_valid(byte_valid),
      .byte_data(byte_data), .is_data(is_data),
      .mode_unsupported(mode_unsupported)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // Scoreboard monitor
   always @(negedge clk) begin
      if (db_oe) oe_seen++;
      if (rst_n && byte_valid) begin
         logic [8:0] e;
         pulses++;
         if (exp_q.size() == 0) begin
            check(1'b0, "R5", "unexpected pulse", {is_data, byte_data}, 0);
         end else begin
            e = exp_q.pop_front();
            check({is_data, byte_data} == e, "R6", "tag/data",
                  {is_data, byte_data}, e);
         end
      end
   end

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic i80_write(input logic [7:0] d, input logic dc,
                            input logic sel, input bit expect_it);
      @(negedge clk);
      bus_sel_n = sel; bus_dc = dc; db_in = d; bus_wr_rw = 1'b0;
      idle(4);
      bus_wr_rw = 1'b1;
      if (expect_it) exp_q.push_back({dc, d});
      idle(5);
      bus_sel_n = 1'b1;
      idle(2);
   endtask

   task automatic m68_write(input logic [7:0] d, input logic dc,
                            input logic rw, input logic sel,
                            input bit expect_it);
      @(negedge clk);
      bus_sel_n = sel; bus_dc = dc; db_in = d; bus_wr_rw = rw;
      bus_rd_en = 1'b1;
      idle(4);
      bus_rd_en = 1'b0;
      if (expect_it) exp_q.push_back({dc, d});
      idle(5);
      bus_sel_n = 1'b1; bus_wr_rw = 1'b1;
      idle(2);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      check(1'b0, "R5", "watchdog expired", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin : stim
      int p0;
      // R8: reset state
      idle(3);
      check(!byte_valid && byte_data == 0 && !is_data, "R8", "reset outputs",
            {is_data, byte_data}, 0);
      check(db_oe == 1'b0, "R7", "db_oe in reset", db_oe, 0);
      // R8: strobe during reset is discarded
      p0 = pulses;
      i80_write(8'h3C, 1'b1, 1'b0, 1'b0);
      check(pulses == p0 && !byte_valid, "R8", "no pulse in reset", pulses, p0);
      rst_n = 1'b1;
      idle(3);

      // R1: supported encoding flag
      check(mode_unsupported == 1'b0, "R1", "8080 flag", mode_unsupported, 0);

      // R5: exact latency of a write-strobe rise
      @(negedge clk);
      bus_sel_n = 1'b0; bus_dc = 1'b0; db_in = 8'hC3; bus_wr_rw = 1'b0;
      idle(4);
      bus_wr_rw = 1'b1;
      exp_q.push_back({1'b0, 8'hC3});
      idle(2);
      check(!byte_valid, "R5", "no pulse before third clock", byte_valid, 0);
      idle(1);
      check(byte_valid, "R5", "pulse in third clock", byte_valid, 1);
      idle(1);
      check(!byte_valid, "R5", "pulse one clock wide", byte_valid, 0);
      bus_sel_n = 1'b1;
      idle(3);

      // R2/R6: strobe-per-direction writes with several patterns
      p0 = pulses;
      i80_write(8'h00, 1'b1, 1'b0, 1'b1);
      i80_write(8'hFF, 1'b0, 1'b0, 1'b1);
      i80_write(8'hA5, 1'b1, 1'b0, 1'b1);
      i80_write(8'h5A, 1'b0, 1'b0, 1'b1);
      check(pulses == p0 + 4, "R2", "four 8080 bytes", pulses, p0 + 4);

      // R2: read strobe toggling is ignored
      p0 = pulses;
      @(negedge clk);
      bus_sel_n = 1'b0;
      for (int i = 0; i < 4; i++) begin
         bus_rd_en = 1'b0; idle(4);
         bus_rd_en = 1'b1; idle(4);
      end
      bus_sel_n = 1'b1;
      idle(4);
      check(pulses == p0, "R2", "read strobe ignored", pulses, p0);

      // R4: chip select high discards strobes
      p0 = pulses;
      i80_write(8'h77, 1'b1, 1'b1, 1'b0);
      check(pulses == p0, "R4", "8080 edge with select off", pulses, p0);

      // Switch to enable style with the bus idle
      bus_rd_en = 1'b0;
      idle(4);
      mode_sel = 3'b011;
      idle(4);
      check(mode_unsupported == 1'b0, "R1", "6800 flag", mode_unsupported, 0);

      // R3/R6: enable-plus-direction writes
      p0 = pulses;
      m68_write(8'h81, 1'b0, 1'b0, 1'b0, 1'b1);
      m68_write(8'h7E, 1'b1, 1'b0, 1'b0, 1'b1);
      m68_write(8'hFF, 1'b1, 1'b0, 1'b0, 1'b1);
      check(pulses == p0 + 3, "R3", "three 6800 bytes", pulses, p0 + 3);

      // R3: direction high is ignored
      p0 = pulses;
      m68_write(8'h44, 1'b1, 1'b1, 1'b0, 1'b0);
      check(pulses == p0, "R3", "edge with direction high", pulses, p0);

      // R4: select off in enable style
      p0 = pulses;
      m68_write(8'h22, 1'b0, 1'b0, 1'b1, 1'b0);
      check(pulses == p0, "R4", "6800 edge with select off", pulses, p0);

      // R1: unsupported encodings
      for (int k = 0; k < 4; k++) begin
         logic [2:0] m;
         m = (k == 0) ? 3'b000 : (k == 1) ? 3'b010 :
             (k == 2) ? 3'b100 : 3'b111;
         bus_rd_en = 1'b0; bus_wr_rw = 1'b1;
         mode_sel = m;
         idle(4);
         check(mode_unsupported == 1'b1, "R1", "unsupported flag",
               mode_unsupported, 1);
         p0 = pulses;
         i80_write(8'h11, 1'b1, 1'b0, 1'b0);
         m68_write(8'h12, 1'b1, 1'b0, 1'b0, 1'b0);
         check(pulses == p0, "R1", "no pulse when unsupported", pulses, p0);
      end

      // Back to 8080 for a final byte
      bus_rd_en = 1'b1; bus_wr_rw = 1'b1;
      mode_sel = 3'b001;
      idle(4);
      i80_write(8'h96, 1'b1, 1'b0, 1'b1);

      idle(6);
      check(exp_q.size() == 0, "R5", "all expected bytes seen", exp_q.size(), 0);
      check(oe_seen == 0, "R7", "db_oe never high", oe_seen, 0);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule